// File: doc/BRIEF.md
# Flash Converter Thermometer-to-Binary Decoder

This block sits behind the comparator bank of a parallel (flash) analog-to-digital converter. A resistor ladder outside the block sets 2^N_BITS - 1 evenly spaced thresholds, each offset by half a step so the conversion rounds to the nearest level. Every comparator whose threshold lies below the input reads high, which forms a thermometer pattern. The decoder samples that pattern on the clock, finds the single place where a high comparator sits directly under a low one, and turns the position into an N_BITS binary code.

A detector on each adjacent pair of comparators fires only when the lower one is high and the upper one is low. Two virtual comparators, fixed high below the bank and fixed low above it, make the all-low and all-high cases produce a boundary as well. Exactly one detector fires for a clean pattern, and the resulting one-hot word is encoded by OR gates. If any high comparator sits above a low one (a bubble), the block raises a one-cycle error flag. For that sample it reports the number of high comparators instead, because this count degrades gracefully.

Top module: `flash_therm_decoder`

## Requirements
- R1: Comparator bit i of `cmp_in` belongs to the (i+1)-th lowest threshold. When the low k bits are high and the rest are low, the code is k.
- R2: When every comparator is low, the code is 0 and the error flag is low.
- R3: When every comparator is high, the code is 2^N_BITS - 1 (7 with the default) and the error flag is low.
- R4: A vector present at a rising edge appears on `code_out` and `bubble_err` after the following rising edge. Before that edge, the outputs still show the previous sample.
- R5: `bubble_err` is high exactly when the sampled vector has some bit i+1 high while bit i is low.
- R6: For a bubbled sample, `code_out` equals the number of high bits in that sample.
- R7: The error flag is tied to its own sample. It lasts one cycle for an isolated bubbled sample and is low again once a clean sample reaches the output.
- R8: A synchronous active-high `rst` clears the registered code and the error flag at the next rising edge.
- R9: With a reference of 7 units and an input of 5.2 units, the five lowest comparators are high (`cmp_in` = 0011111) and the code is binary 101.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cmp_in | input | 2**N_BITS-1 | Comparator outputs, bit 0 lowest threshold |
| code_out | output | N_BITS | Registered binary code |
| bubble_err | output | 1 | High for a sample that was not a thermometer code |

## Verification
The assertions assume that `cmp_in` is settled and free of unknowns at every rising edge after reset. They do not wait for the comparators to form a clean thermometer code; bubbled inputs are a legal case. The bench changes the vector only on falling edges and holds each value for two full cycles. Clean patterns, bubbled patterns and both extremes all reach the sampling edge at stable levels.

// File: rtl/flash_dec_pkg.sv
package flash_dec_pkg;

    localparam int DEF_BITS = 3;

    typedef enum logic {
        SRC_BOUNDARY = 1'b0,
        SRC_COUNT    = 1'b1
    } code_src_e;

endpackage

// File: rtl/fd_boundary.sv
module fd_boundary #(
    parameter int NUM_CMP = 7
) (
    input  logic [NUM_CMP-1:0] cmp,
    output logic [NUM_CMP:0]   onehot
);

    localparam int EXT_W = NUM_CMP + 2;

    logic [EXT_W-1:0] ext;

    // virtual comparator below the bank reads high, the one above reads low
    assign ext = {1'b0, cmp, 1'b1};

    genvar g;
    generate
        for (g = 0; g <= NUM_CMP; g++) begin : g_pair
            assign onehot[g] = ext[g] & ~ext[g+1];
        end
    endgenerate

endmodule

// File: rtl/fd_or_encode.sv
module fd_or_encode #(
    parameter int N_BITS = 3,
    parameter int IN_W   = 8
) (
    input  logic [IN_W-1:0]   onehot,
    output logic [N_BITS-1:0] code
);

    genvar b;
    generate
        for (b = 0; b < N_BITS; b++) begin : g_bit
            always_comb begin
                code[b] = 1'b0;
                for (int i = 0; i < IN_W; i++) begin
                    if (((i >> b) & 1) == 1) begin
                        code[b] = code[b] | onehot[i];
                    end
                end
            end
        end
    endgenerate

endmodule

// File: rtl/fd_bubble_check.sv
module fd_bubble_check #(
    parameter int N_BITS  = 3,
    parameter int NUM_CMP = 7
) (
    input  logic [NUM_CMP-1:0] cmp,
    output logic               bubble,
    output logic [N_BITS-1:0]  ones
);

    logic [NUM_CMP-1:0] inv_pair;

    genvar g;
    generate
        assign inv_pair[0] = 1'b0;
        for (g = 1; g < NUM_CMP; g++) begin : g_inv
            assign inv_pair[g] = cmp[g] & ~cmp[g-1];
        end
    endgenerate

    assign bubble = |inv_pair;

    always_comb begin
        ones = '0;
        for (int i = 0; i < NUM_CMP; i++) begin
            ones = ones + N_BITS'(cmp[i]);
        end
    end

endmodule

// File: rtl/flash_therm_decoder.sv
module flash_therm_decoder
    import flash_dec_pkg::*;
#(
    parameter int N_BITS = DEF_BITS
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [(2**N_BITS)-2:0]    cmp_in,
    output logic [N_BITS-1:0]         code_out,
    output logic                      bubble_err
);

    localparam int NUM_CMP = (2**N_BITS) - 1;
    localparam int OH_W    = NUM_CMP + 1;

    typedef struct packed {
        logic [NUM_CMP-1:0] smp;
        logic [N_BITS-1:0]  code;
        logic               err;
    } dec_state_t;

    dec_state_t st_d, st_q;

    logic [OH_W-1:0]   oh_w;
    logic [N_BITS-1:0] enc_code_w;
    logic [N_BITS-1:0] ones_w;
    logic              bubble_w;
    code_src_e         src_w;

    fd_boundary #(.NUM_CMP(NUM_CMP)) boundary_i (
        .cmp    (st_q.smp),
        .onehot (oh_w)
    );

    fd_or_encode #(.N_BITS(N_BITS), .IN_W(OH_W)) encode_i (
        .onehot (oh_w),
        .code   (enc_code_w)
    );

    fd_bubble_check #(.N_BITS(N_BITS), .NUM_CMP(NUM_CMP)) bubble_i (
        .cmp    (st_q.smp),
        .bubble (bubble_w),
        .ones   (ones_w)
    );

    assign src_w = bubble_w ? SRC_COUNT : SRC_BOUNDARY;

    always_comb begin
        st_d     = st_q;
        st_d.smp = cmp_in;
        st_d.err = bubble_w;
        case (src_w)
            SRC_COUNT:    st_d.code = ones_w;
            default:      st_d.code = enc_code_w;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign code_out   = st_q.code;
    assign bubble_err = st_q.err;

endmodule

// File: rtl/flash_therm_decoder_chk.sv
module flash_therm_decoder_chk #(
    parameter int N_BITS = 3
) (
    input logic                   clk,
    input logic                   rst,
    input logic [(2**N_BITS)-2:0] cmp_in,
    input logic [N_BITS-1:0]      code_out,
    input logic                   bubble_err
);

    localparam int NUM_CMP = (2**N_BITS) - 1;

    logic [1:0] age_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            age_q <= 2'd0;
        end else if (age_q != 2'd2) begin
            age_q <= age_q + 2'd1;
        end
    end

    function automatic logic not_thermo(input logic [NUM_CMP-1:0] v);
        logic r;
        r = 1'b0;
        for (int i = 1; i < NUM_CMP; i++) begin
            if (v[i] && !v[i-1]) r = 1'b1;
        end
        return r;
    endfunction

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (code_out == '0 && !bubble_err)); // R8

    AST_FLAG_MATCHES: assert property (@(posedge clk) disable iff (rst)
        age_q == 2'd2 |-> bubble_err == not_thermo($past(cmp_in, 2))); // R5

    AST_CLEAN_CODE: assert property (@(posedge clk) disable iff (rst)
        (age_q == 2'd2 && !bubble_err) |-> code_out == N_BITS'($countones($past(cmp_in, 2)))); // R1

    AST_BUBBLE_COUNT: assert property (@(posedge clk) disable iff (rst)
        (age_q == 2'd2 && bubble_err) |-> code_out == N_BITS'($countones($past(cmp_in, 2)))); // R6

    AST_ALL_LOW: assert property (@(posedge clk) disable iff (rst)
        (age_q == 2'd2 && $past(cmp_in, 2) == '0) |-> (code_out == '0 && !bubble_err)); // R2

    AST_ALL_HIGH: assert property (@(posedge clk) disable iff (rst)
        (age_q == 2'd2 && $past(cmp_in, 2) == '1) |-> (code_out == '1 && !bubble_err)); // R3

endmodule

bind flash_therm_decoder flash_therm_decoder_chk #(.N_BITS(N_BITS)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .cmp_in     (cmp_in),
    .code_out   (code_out),
    .bubble_err (bubble_err)
);

// File: tb/flash_therm_decoder_tb_top.sv
module flash_therm_decoder_tb_top;

    localparam int N_BITS  = 3;
    localparam int NUM_CMP = 7;
    localparam int NVEC    = 13;

    typedef struct packed {
        logic [6:0] cmp;
        logic [2:0] code;
        logic       err;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{7'b0000000, 3'd0, 1'b0},  // R2
        '{7'b0000001, 3'd1, 1'b0},  // R1
        '{7'b0000011, 3'd2, 1'b0},  // R1
        '{7'b0000111, 3'd3, 1'b0},  // R1
        '{7'b0001111, 3'd4, 1'b0},  // R1
        '{7'b0011111, 3'd5, 1'b0},  // R9
        '{7'b0111111, 3'd6, 1'b0},  // R1
        '{7'b1111111, 3'd7, 1'b0},  // R3
        '{7'b0000010, 3'd1, 1'b1},  // R5 R6
        '{7'b0001011, 3'd3, 1'b1},  // R5 R6
        '{7'b1010101, 3'd4, 1'b1},  // R5 R6
        '{7'b1111110, 3'd6, 1'b1},  // R5 R6
        '{7'b0110111, 3'd5, 1'b1}   // R5 R6
    };

    logic               clk;
    logic               rst;
    logic [NUM_CMP-1:0] cmp_in;
    logic [N_BITS-1:0]  code_out;
    logic               bubble_err;

    int n_tests;
    int n_fail;

    flash_therm_decoder #(.N_BITS(N_BITS)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .cmp_in     (cmp_in),
        .code_out   (code_out),
        .bubble_err (bubble_err)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    task automatic check(input string req, input logic [2:0] exp_code, input logic exp_err);
        n_tests++;
        if (code_out !== exp_code || bubble_err !== exp_err) begin
            n_fail++;
            $display("FAIL %s: code=%0d err=%0b expected code=%0d err=%0b",
                     req, code_out, bubble_err, exp_code, exp_err);
        end
    endtask

    task automatic apply(input logic [6:0] v);
        @(negedge clk);
        cmp_in = v;
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        n_tests = 0;
        n_fail  = 0;
        rst     = 1'b1;
        cmp_in  = '0;
        repeat (3) @(negedge clk);
        check("R8 reset state", 3'd0, 1'b0);
        rst = 1'b0;

        for (int i = 0; i < NVEC; i++) begin
            apply(VECS[i].cmp);
            check($sformatf("R1/R5 vector %0d", i), VECS[i].code, VECS[i].err);
        end

        // R4: latency, output holds old code until second edge
        apply(7'b0000011);
        @(negedge clk);
        cmp_in = 7'b0111111;
        @(negedge clk);
        check("R4 before update", 3'd2, 1'b0);
        @(negedge clk);
        check("R4 after update", 3'd6, 1'b0);

        // R7: isolated bubble flag lasts one cycle
        @(negedge clk);
        cmp_in = 7'b0000101;
        @(negedge clk);
        cmp_in = 7'b0000111;
        @(negedge clk);
        check("R7 bubble cycle", 3'd2, 1'b1);
        @(negedge clk);
        check("R7 flag cleared", 3'd3, 1'b0);

        // R8: reset clears outputs while a bubble is pending
        apply(7'b1010101);
        check("R8 pre-reset", 3'd4, 1'b1);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R8 reset clears", 3'd0, 1'b0);
        rst = 1'b0;
        apply(7'b1111111);
        check("R3 after reset", 3'd7, 1'b0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule